// File: doc/BRIEF.md
# Sub-Field Register File

A 32-entry, 32-bit register file. Every read and write access names a field inside a register instead of the whole word. The field is given as a resolved bit offset (0 to 31) and a width code that selects one bit, one byte, one halfword or the full word. Nested selectors are resolved to this offset before they reach the block. For example, "halfword at byte 2, then byte 1 inside it" becomes byte offset 3, which is bit offset 24. Two read ports return fields zero-extended to 32 bits, with no clock delay. One write port merges a field into a register at the clock edge and leaves all other bits unchanged.

Two registers are tied to pins. The word in register 30 drives 32 output pins directly. Register 31 has no storage. A read of register 31 returns the 30 input pins in bits 29..0, host interrupt 0 in bit 30 and host interrupt 1 in bit 31. A write to register 31 produces an event instead of storing data. A field descriptor that runs past bit 31 is illegal. A write with such a descriptor changes nothing and raises an error flag for one cycle.

Top module: `fieldsel_regfile`

## Requirements
- R1: After a clock edge with `rst_n` low, every stored register holds zero and `pins_out`, `evt_vec`, `evt_pulse` and `wr_err` are zero.
- R2: A read port returns `(word >> offset) & mask`, combinationally. The width codes are: 0 = 1 bit (mask 0x1), 1 = byte (0xFF), 2 = halfword (0xFFFF), 3 = word (all ones). Bits at or above position 32 read as zero.
- R3: A legal write takes the low field-width bits of the write data and places them at the offset. It leaves every other bit of the register unchanged. The new value is visible from the next rising edge, and a read of the same register in the write cycle returns the old value.
- R4: A byte selector n is bit offset 8n, and a halfword selector n (n = 0 to 2) is bit offset 8n. So halfword 1 covers bits 23..8 and the nested byte 1 of halfword 2 equals byte 3.
- R5: `pins_out` always equals the stored content of register 30. It changes only in the cycle after a legal write to register 30.
- R6: A read of register 31 returns `{host_irq[1], host_irq[0], pins_in[29:0]}`, with the field taken as in R2.
- R7: A legal write to register 31 stores nothing. Its field is placed at its offset in an otherwise-zero word. If bit 5 of that word is 1, then in the next cycle `evt_pulse` is high for one cycle and `evt_vec` takes bits 4..0, which it holds until the next event. Otherwise no pulse occurs.
- R8: A write whose offset plus width exceeds 32 changes no register and no output pin and produces no event. `wr_err` is high in the following cycle only, and it is low after any legal write or idle cycle.
- R9: The two read ports are independent and may read any two fields of any registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ra_idx | input | 5 | Read port A register number |
| ra_off | input | 5 | Read port A field bit offset |
| ra_wid | input | 2 | Read port A width code |
| ra_data | output | 32 | Read port A zero-extended field |
| rb_idx | input | 5 | Read port B register number |
| rb_off | input | 5 | Read port B field bit offset |
| rb_wid | input | 2 | Read port B width code |
| rb_data | output | 32 | Read port B zero-extended field |
| we | input | 1 | Write enable |
| wa_idx | input | 5 | Write register number |
| wa_off | input | 5 | Write field bit offset |
| wa_wid | input | 2 | Write width code |
| wa_data | input | 32 | Write data, field taken from its low bits |
| pins_in | input | 30 | Input pins seen in register 31 |
| host_irq | input | 2 | Host interrupt status seen in register 31 bits 31..30 |
| pins_out | output | 32 | Output pins driven from register 30 |
| evt_vec | output | 5 | Last event vector |
| evt_pulse | output | 1 | One-cycle event strobe |
| wr_err | output | 1 | One-cycle illegal-descriptor flag |

## Verification
Read data is due in the same cycle as its address, with zero cycles of delay. A stored write shows on a read port after one rising edge. `pins_out`, `evt_pulse`, `evt_vec` and `wr_err` each change one edge after the write that caused them. The bench drives every input just after a falling edge and compares both read ports one time unit later. It then compares the registered outputs at the next falling edge, before new inputs are applied. Its behavioural model updates at the rising edge between these two points, so each result is compared in exactly the cycle it becomes due.

// File: rtl/fieldsel_regfile.sv
module fieldsel_regfile #(
  parameter int XLEN     = 32,
  parameter int NREG     = 32,
  parameter int OUT_IDX  = 30,
  parameter int STAT_IDX = 31,
  parameter int EVW      = 5,
  localparam int IW      = $clog2(NREG),
  localparam int OW      = $clog2(XLEN),
  localparam int NPIN    = XLEN - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   ra_idx,
  input  logic [OW-1:0]   ra_off,
  input  logic [1:0]      ra_wid,
  output logic [XLEN-1:0] ra_data,
  input  logic [IW-1:0]   rb_idx,
  input  logic [OW-1:0]   rb_off,
  input  logic [1:0]      rb_wid,
  output logic [XLEN-1:0] rb_data,
  input  logic            we,
  input  logic [IW-1:0]   wa_idx,
  input  logic [OW-1:0]   wa_off,
  input  logic [1:0]      wa_wid,
  input  logic [XLEN-1:0] wa_data,
  input  logic [NPIN-1:0] pins_in,
  input  logic [1:0]      host_irq,
  output logic [XLEN-1:0] pins_out,
  output logic [EVW-1:0]  evt_vec,
  output logic            evt_pulse,
  output logic            wr_err
);

  function automatic logic [XLEN-1:0] fmask(input logic [1:0] w);
    case (w)
      2'd0:    fmask = XLEN'(1);
      2'd1:    fmask = XLEN'(8'hFF);
      2'd2:    fmask = XLEN'(16'hFFFF);
      default: fmask = '1;
    endcase
  endfunction

  function automatic int fbits(input logic [1:0] w);
    case (w)
      2'd0:    fbits = 1;
      2'd1:    fbits = 8;
      2'd2:    fbits = 16;
      default: fbits = XLEN;
    endcase
  endfunction

  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] stat_word, ra_src, rb_src;
  logic [XLEN-1:0] wr_fmask, wr_bits;
  logic            wr_ok, wr_stat;

  assign stat_word = {host_irq, pins_in};
  assign ra_src    = (int'(ra_idx) == STAT_IDX) ? stat_word : regs[ra_idx];
  assign rb_src    = (int'(rb_idx) == STAT_IDX) ? stat_word : regs[rb_idx];
  assign ra_data   = (ra_src >> ra_off) & fmask(ra_wid);
  assign rb_data   = (rb_src >> rb_off) & fmask(rb_wid);

  assign wr_ok    = (int'(wa_off) + fbits(wa_wid)) <= XLEN;
  assign wr_fmask = fmask(wa_wid) << wa_off;
  assign wr_bits  = (wa_data & fmask(wa_wid)) << wa_off;
  assign wr_stat  = we && wr_ok && (int'(wa_idx) == STAT_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wr_ok && int'(wa_idx) != STAT_IDX) begin
      regs[wa_idx] <= (regs[wa_idx] & ~wr_fmask) | wr_bits;
    end
  end

  assign pins_out = regs[OUT_IDX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_pulse <= 1'b0;
      evt_vec   <= '0;
      wr_err    <= 1'b0;
    end else begin
      evt_pulse <= wr_stat && wr_bits[EVW];
      if (wr_stat && wr_bits[EVW]) evt_vec <= wr_bits[EVW-1:0];
      wr_err    <= we && !wr_ok;
    end
  end

  assert_err_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (int'(wa_off) + fbits(wa_wid) > XLEN)) |=> wr_err);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!we) |=> !wr_err);

  assert_out_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && int'(wa_idx) == OUT_IDX) |=> $stable(pins_out));

  assert_evt_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> $past(we && int'(wa_idx) == STAT_IDX));

  assert_bit_zext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_wid == 2'd0) |-> ((ra_data >> 1) == '0));

endmodule

// File: tb/fieldsel_regfile_test.sv
module fieldsel_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic [4:0]  ra_idx, ra_off, rb_idx, rb_off, wa_idx, wa_off;
  logic [1:0]  ra_wid, rb_wid, wa_wid, host_irq;
  logic [31:0] ra_data, rb_data, wa_data, pins_out;
  logic        we, evt_pulse, wr_err;
  logic [29:0] pins_in;
  logic [4:0]  evt_vec;

  fieldsel_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(ra_idx), .ra_off(ra_off), .ra_wid(ra_wid), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_off(rb_off), .rb_wid(rb_wid), .rb_data(rb_data),
    .we(we), .wa_idx(wa_idx), .wa_off(wa_off), .wa_wid(wa_wid), .wa_data(wa_data),
    .pins_in(pins_in), .host_irq(host_irq),
    .pins_out(pins_out), .evt_vec(evt_vec), .evt_pulse(evt_pulse), .wr_err(wr_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_regs [32];
  logic [4:0]  m_vec;
  logic        m_pulse, m_err;

  function automatic int bw(int c);
    case (c)
      0: return 1;
      1: return 8;
      2: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] getf(logic [31:0] v, int off, int c);
    logic [31:0] r = '0;
    for (int i = 0; i < bw(c); i++) if (off + i < 32) r[i] = v[off + i];
    return r;
  endfunction

  function automatic logic [31:0] place(logic [31:0] d, int off, int c);
    logic [31:0] r = '0;
    for (int i = 0; i < bw(c); i++) if (off + i < 32) r[off + i] = d[i];
    return r;
  endfunction

  function automatic logic [31:0] src(int idx);
    if (idx == 31) return {host_irq, pins_in};
    return m_regs[idx];
  endfunction

  task automatic chk(string ctx, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", ctx, what, got, exp);
    end
  endtask

  task automatic cyc(string ctx, bit w, int widx, int woff, int wcd, logic [31:0] wd,
                     int ai, int ao, int ac, int bi, int bo, int bc);
    bit ok;
    logic [31:0] p, fm, nv;
    logic n_pulse, n_err;
    logic [4:0] n_vec;
    @(negedge clk);
    chk(ctx, "R5 pins_out", pins_out, m_regs[30]);
    chk(ctx, "R7 evt_pulse", 32'(evt_pulse), 32'(m_pulse));
    chk(ctx, "R7 evt_vec", 32'(evt_vec), 32'(m_vec));
    chk(ctx, "R8 wr_err", 32'(wr_err), 32'(m_err));
    we = w; wa_idx = 5'(widx); wa_off = 5'(woff); wa_wid = 2'(wcd); wa_data = wd;
    ra_idx = 5'(ai); ra_off = 5'(ao); ra_wid = 2'(ac);
    rb_idx = 5'(bi); rb_off = 5'(bo); rb_wid = 2'(bc);
    #1;
    chk(ctx, "R2 ra_data", ra_data, getf(src(ai), ao, ac));
    chk(ctx, "R9 rb_data", rb_data, getf(src(bi), bo, bc));
    ok = (woff + bw(wcd)) <= 32;
    n_err = w && !ok;
    n_pulse = 1'b0;
    n_vec = m_vec;
    nv = m_regs[widx];
    if (w && ok) begin
      p = place(wd, woff, wcd);
      if (widx == 31) begin
        if (p[5]) begin n_pulse = 1'b1; n_vec = p[4:0]; end
      end else begin
        fm = place(32'hFFFF_FFFF, woff, wcd);
        nv = (nv & ~fm) | p;
      end
    end
    @(posedge clk);
    if (w && ok && widx != 31) m_regs[widx] = nv;
    m_pulse = n_pulse; m_vec = n_vec; m_err = n_err;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; we = 0; wa_idx = 0; wa_off = 0; wa_wid = 0; wa_data = 0;
    ra_idx = 0; ra_off = 0; ra_wid = 0; rb_idx = 0; rb_off = 0; rb_wid = 0;
    pins_in = '0; host_irq = '0;
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    m_vec = '0; m_pulse = 0; m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the pins
    chk("R1 reset", "R1 pins_out", pins_out, 32'h0);
    chk("R1 reset", "R1 evt_vec", 32'(evt_vec), 32'h0);
    chk("R1 reset", "R1 evt_pulse", 32'(evt_pulse), 32'h0);
    chk("R1 reset", "R1 wr_err", 32'(wr_err), 32'h0);
    rst_n = 1;
    cyc("R1 post-reset", 0, 0, 0, 0, 0, 5, 0, 3, 30, 0, 3);
    // R3: merge writes, same-cycle read sees old value
    cyc("R3 word write", 1, 3, 0, 3, 32'h1234_5678, 3, 0, 3, 3, 0, 3);
    cyc("R3 readback", 0, 0, 0, 0, 0, 3, 0, 3, 3, 16, 1);
    cyc("R3 byte merge", 1, 3, 16, 1, 32'hFFFF_FFAB, 3, 16, 1, 3, 0, 3);
    cyc("R3 merged", 0, 0, 0, 0, 0, 3, 0, 3, 3, 16, 1);
    cyc("R3 bit set", 1, 3, 0, 0, 32'hFFFF_FFFF, 3, 0, 0, 3, 0, 3);
    // R4: halfword at byte 1, nested selectors
    cyc("R4 half at byte1", 1, 4, 8, 2, 32'h0000_CDEF, 4, 0, 3, 4, 8, 2);
    cyc("R4 nested byte3", 0, 0, 0, 0, 0, 4, 0, 3, 3, 24, 1);
    cyc("R4 bit19", 0, 0, 0, 0, 0, 3, 19, 0, 4, 28, 0);
    // R5: output pins
    cyc("R5 out write", 1, 30, 0, 3, 32'hA5A5_0F0F, 30, 0, 3, 30, 8, 1);
    cyc("R5 out byte", 1, 30, 8, 1, 32'h0000_003C, 30, 0, 3, 30, 8, 1);
    cyc("R5 out hold", 0, 0, 0, 0, 0, 30, 0, 3, 30, 16, 2);
    // R6: status read
    pins_in = 30'h2AAA_AAAA; host_irq = 2'b10;
    cyc("R6 status read", 0, 0, 0, 0, 0, 31, 0, 3, 31, 30, 0);
    cyc("R6 irq bit31", 0, 0, 0, 0, 0, 31, 31, 0, 31, 0, 2);
    // R7: event writes
    cyc("R7 event write", 1, 31, 0, 3, 32'h0000_0025, 31, 0, 3, 30, 0, 3);
    cyc("R7 no store", 0, 0, 0, 0, 0, 31, 0, 3, 31, 0, 1);
    cyc("R7 no valid", 1, 31, 0, 3, 32'h0000_001F, 31, 0, 3, 0, 0, 3);
    cyc("R7 bit valid", 1, 31, 5, 0, 32'h1, 31, 0, 3, 0, 0, 3);
    cyc("R7 after", 0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 3);
    // R8: illegal descriptors
    cyc("R8 illegal half", 1, 30, 20, 2, 32'hFFFF, 30, 0, 3, 30, 16, 2);
    cyc("R8 illegal status", 1, 31, 27, 1, 32'hFF, 30, 0, 3, 31, 0, 3);
    cyc("R8 illegal word", 1, 3, 1, 3, 32'hFFFF_FFFF, 3, 0, 3, 3, 1, 3);
    cyc("R8 legal edge", 1, 5, 24, 1, 32'h77, 5, 0, 3, 3, 0, 3);
    cyc("R8 idle", 0, 0, 0, 0, 0, 5, 24, 1, 5, 31, 0);
    // R9: independent ports
    cyc("R9 dual ports", 0, 0, 0, 0, 0, 3, 8, 2, 30, 4, 1);
    // Mixed traffic checked against the model every cycle
    for (int k = 0; k < 3000; k++) begin
      int c, off;
      c = $urandom % 4;
      off = (k % 3 == 0) ? ($urandom % 32) : ($urandom % (33 - bw(c)));
      if (k % 50 == 0) begin pins_in = 30'($urandom); host_irq = 2'($urandom); end
      cyc("R3 random", ($urandom % 4) != 0, $urandom % 32, off, c, $urandom,
          $urandom % 32, $urandom % 32, $urandom % 4,
          $urandom % 32, $urandom % 32, $urandom % 4);
    end
    cyc("R8 final", 0, 0, 0, 0, 0, 30, 0, 3, 31, 0, 3);
    done = 1;
    summary();
    $finish;
  end
endmodule